// File: doc/BRIEF.md
# Stereo Soft-Mute and Attenuation Gain Stage

This block applies a per-sample gain to a stream of stereo sample pairs. Each pair arrives with a one-cycle valid strobe. The gain is taken from a 32-entry raised-cosine table.

While the active-low mute control is held low, the table index walks down towards zero, so the output fades smoothly to exact silence. When mute is released, the index climbs back through the same entries in reverse order until the output is at unity gain again. Every table entry is used for 31 consecutive sample pairs before the index moves on.

A second active-low control cuts the level by 12 dB, which is a division by four. Both controls are read only when a sample pair is accepted, so a gain change never lands inside a word. The block sits in an audio datapath between the serial-input deserialiser and the up-sampling filters.

Top module: `softmute_gain`

## Requirements
- R1: After reset, out_valid is 0, both outputs are 0, and the ramp index sits at the top entry (31), so the first pairs sent with mute_n high leave the block unchanged.
- R2: Each accepted pair produces exactly one out_valid pulse two clock edges after the edge that accepts it. Each channel output is round(x*c/32768), where c is the coefficient at the ramp index in force when the pair was accepted, and rounding adds one half and then shifts right arithmetically.
- R3: Coefficient i, for i in 0..31, is round(32768*(1-cos(pi*i/31))/2). Entry 31 equals 32768, which is exact unity gain, and entry 0 gives an output of exactly 0 for any input.
- R4: While mute_n is 0 at each strobe, the index is held for 31 accepted pairs and then decreases by one. Starting from 31, the output is 0 from the 962nd pair onwards and stays 0.
- R5: While mute_n is 1 at each strobe, the index rises through the same entries in reverse order with the same 31-pair hold, up to 31 and no further.
- R6: A change of mute_n in the middle of a ramp reverses the direction from the current index, with no jump. The pair on which the change is seen counts as the first of a fresh 31-pair hold.
- R7: With atten_n at 0 on a strobe, that pair's output is round(x*c/131072), which is one quarter of the unattenuated gain. With atten_n at 1 the extra factor is 1.
- R8: mute_n and atten_n are sampled only on cycles where in_valid is 1. Their values on other cycles have no effect on the ramp or on any output.
- R9: Results are rounded half-up and clamped to the signed 20-bit range, including the full-scale inputs -524288 and 524287.
- R10: Between pulses, out_valid is 0 and both outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking an accepted sample pair |
| in_left | input | 20 | Left sample, signed two's complement |
| in_right | input | 20 | Right sample, signed two's complement |
| mute_n | input | 1 | Soft mute request, active low |
| atten_n | input | 1 | 12 dB cut request, active low |
| out_valid | output | 1 | Strobe marking a scaled pair |
| out_left | output | 20 | Scaled left sample |
| out_right | output | 20 | Scaled right sample |

## Verification
A scaled pair is due exactly two edges after its strobe: one edge for the coefficient read and the input registers, and one for the multiply, round and clamp. The bench drives each pair for a single cycle and checks at the falling edge after the second rising edge. It also checks at the falling edge in between that out_valid is still low and the previous result is unchanged. The ramp state in the bench model advances once per strobe and never per cycle, so the 31-pair holds are counted in pairs. Between strobes the bench drives both controls to the opposite of their strobe values, so any sampling outside a strobe would show up as an output mismatch.

// File: rtl/softmute_pkg.sv
package softmute_pkg;

  // Raised-cosine gain entry for index i of an n-entry ramp, unsigned with
  // frac fractional bits; entry 0 is zero, entry n-1 is exactly 1.0.
  function automatic int cos_coef(input int i, input int n, input int frac);
    real x;
    real term;
    real sum;
    x = 3.14159265358979323846 * real'(i) / real'(n - 1);
    term = 1.0;
    sum = 1.0;
    for (int k = 1; k <= 24; k++) begin
      term = -term * x * x / (real'(2 * k - 1) * real'(2 * k));
      sum = sum + term;
    end
    return $rtoi(real'(1 << frac) * (1.0 - sum) / 2.0 + 0.5);
  endfunction

endpackage

// File: rtl/softmute_rom.sv
module softmute_rom #(
  parameter int STEPS  = 32,
  parameter int FRAC   = 15,
  parameter int COEF_W = FRAC + 1,
  parameter int IDX_W  = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [COEF_W-1:0] rd_coef
);
  import softmute_pkg::*;

  logic [COEF_W-1:0] table_mem [STEPS];

  for (genvar g = 0; g < STEPS; g++) begin : g_entry
    localparam logic [COEF_W-1:0] ENTRY = COEF_W'(cos_coef(g, STEPS, FRAC));
    assign table_mem[g] = ENTRY;
  end

  // registered read, block-RAM style
  always_ff @(posedge clk) begin
    if (rd_en) rd_coef <= table_mem[rd_idx];
  end

endmodule

// File: rtl/softmute_ramp.sv
module softmute_ramp #(
  parameter int STEPS = 32,
  parameter int HOLD  = 31,
  parameter int IDX_W = $clog2(STEPS),
  parameter int CNT_W = $clog2(HOLD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             mute_req,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(STEPS - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD - 1);

  logic [CNT_W-1:0] hold_cnt;
  logic             mute_prev;
  logic             at_target;

  always_comb at_target = mute_req ? (idx == '0) : (idx == TOP_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= TOP_IDX;
      hold_cnt  <= '0;
      mute_prev <= 1'b0;
    end else if (step) begin
      mute_prev <= mute_req;
      if (at_target) begin
        hold_cnt <= '0;
      end else if (mute_req != mute_prev) begin
        hold_cnt <= CNT_W'(1);
      end else if (hold_cnt == LAST_CNT) begin
        hold_cnt <= '0;
        idx      <= mute_req ? idx - 1'b1 : idx + 1'b1;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/softmute_scale.sv
module softmute_scale #(
  parameter int DATA_W = 20,
  parameter int FRAC   = 15,
  parameter int COEF_W = FRAC + 1,
  parameter int CUT_SH = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] sample,
  input  logic [COEF_W-1:0]        coef,
  input  logic                     cut,
  output logic signed [DATA_W-1:0] result
);
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam int SH_N   = FRAC;
  localparam int SH_C   = FRAC + CUT_SH;
  localparam logic signed [PROD_W-1:0] HALF_N = PROD_W'(1) <<< (SH_N - 1);
  localparam logic signed [PROD_W-1:0] HALF_C = PROD_W'(1) <<< (SH_C - 1);
  localparam logic signed [PROD_W-1:0] MAXV   = (PROD_W'(1) <<< (DATA_W - 1)) - 1;
  localparam logic signed [PROD_W-1:0] MINV   = -(PROD_W'(1) <<< (DATA_W - 1));

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] biased;
  logic signed [PROD_W-1:0] shifted;
  logic signed [DATA_W-1:0] clamped;

  always_comb begin
    prod    = sample * $signed({1'b0, coef});
    biased  = prod + (cut ? HALF_C : HALF_N);
    shifted = cut ? (biased >>> SH_C) : (biased >>> SH_N);
    if (shifted > MAXV)      clamped = MAXV[DATA_W-1:0];
    else if (shifted < MINV) clamped = MINV[DATA_W-1:0];
    else                     clamped = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     result <= '0;
    else if (en) result <= clamped;
  end

endmodule

// File: rtl/softmute_gain.sv
module softmute_gain #(
  parameter int DATA_W = 20,
  parameter int FRAC   = 15,
  parameter int STEPS  = 32,
  parameter int HOLD   = 31,
  parameter int CUT_SH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic              mute_n,
  input  logic              atten_n,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right
);
  localparam int COEF_W = FRAC + 1;
  localparam int IDX_W  = $clog2(STEPS);
  localparam int CNT_W  = $clog2(HOLD);
  localparam int NCH    = 2;

  logic [IDX_W-1:0]  ramp_idx;
  logic [COEF_W-1:0] s1_coef;
  logic              s1_valid;
  logic              s1_cut;
  logic [DATA_W-1:0] s1_data  [NCH];
  logic [DATA_W-1:0] ch_in    [NCH];
  logic [DATA_W-1:0] ch_out   [NCH];

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  softmute_ramp #(
    .STEPS(STEPS), .HOLD(HOLD), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) ramp_i (
    .clk(clk), .rst(rst), .step(in_valid), .mute_req(~mute_n), .idx(ramp_idx)
  );

  softmute_rom #(
    .STEPS(STEPS), .FRAC(FRAC), .COEF_W(COEF_W), .IDX_W(IDX_W)
  ) rom_i (
    .clk(clk), .rd_en(in_valid), .rd_idx(ramp_idx), .rd_coef(s1_coef)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_cut    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
      if (in_valid) s1_cut <= ~atten_n;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (in_valid) s1_data[c] <= ch_in[c];
    end

    softmute_scale #(
      .DATA_W(DATA_W), .FRAC(FRAC), .COEF_W(COEF_W), .CUT_SH(CUT_SH)
    ) scale_i (
      .clk(clk), .rst(rst), .en(s1_valid), .sample(s1_data[c]),
      .coef(s1_coef), .cut(s1_cut), .result(ch_out[c])
    );
  end

  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

endmodule

// File: rtl/softmute_gain_chk.sv
module softmute_gain_chk #(
  parameter int DATA_W = 20,
  parameter int COEF_W = 16,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              mute_n,
  input logic [IDX_W-1:0]  ramp_idx,
  input logic              s1_valid,
  input logic [COEF_W-1:0] s1_coef,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right
);
  AST_STROBE_STAGE1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid); // R2
  AST_STROBE_OUT: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid); // R2
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !out_valid); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> ($stable(out_left) && $stable(out_right))); // R10
  AST_ZERO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_coef == '0) |=> (out_left == '0 && out_right == '0)); // R3
  AST_IDX_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ramp_idx)); // R8
  AST_MUTE_DOWN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mute_n) |=> (ramp_idx <= $past(ramp_idx))); // R4
  AST_RELEASE_UP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mute_n) |=> (ramp_idx >= $past(ramp_idx))); // R5
  AST_NO_JUMP: assert property (@(posedge clk) disable iff (rst)
    !$stable(ramp_idx) |-> (ramp_idx == $past(ramp_idx) + 1'b1 ||
                            ramp_idx == $past(ramp_idx) - 1'b1)); // R6
endmodule

bind softmute_gain softmute_gain_chk #(
  .DATA_W(DATA_W), .COEF_W(COEF_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mute_n(mute_n),
  .ramp_idx(ramp_idx), .s1_valid(s1_valid), .s1_coef(s1_coef),
  .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
);

// File: tb/softmute_gain_tb.sv
module softmute_gain_tb_top;
  localparam int DW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_left = '0;
  logic [DW-1:0] in_right = '0;
  logic          mute_n = 1'b1;
  logic          atten_n = 1'b1;
  logic          out_valid;
  logic [DW-1:0] out_left;
  logic [DW-1:0] out_right;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // bench model state
  int    m_idx = 31;
  int    m_cnt = 0;
  bit    m_prev = 1'b0;
  longint last_l = 0;
  longint last_r = 0;
  string phase = "R2";

  always #4 clk = ~clk;

  softmute_gain dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .mute_n(mute_n), .atten_n(atten_n),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  function automatic longint coef_of(input int i);
    return longint'($rtoi(32768.0 * (1.0 - $cos(3.141592653589793 * real'(i) / 31.0)) / 2.0 + 0.5));
  endfunction

  function automatic longint scale(input longint x, input longint c, input bit cut);
    longint p;
    longint r;
    int sh;
    sh = cut ? 17 : 15;
    p = x * c + (longint'(1) <<< (sh - 1));
    r = p >>> sh;
    if (r > 524287) r = 524287;
    if (r < -524288) r = -524288;
    return r;
  endfunction

  function automatic longint sx(input logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // model update, applied once per accepted pair (R4, R5, R6)
  task automatic model_step(input bit mreq);
    bit at_t;
    at_t = mreq ? (m_idx == 0) : (m_idx == 31);
    if (at_t) m_cnt = 0;
    else if (mreq != m_prev) m_cnt = 1;
    else if (m_cnt == 30) begin
      m_cnt = 0;
      m_idx = mreq ? m_idx - 1 : m_idx + 1;
    end else m_cnt++;
    m_prev = mreq;
  endtask

  // one pair: driven at a falling edge, checked two rising edges later
  task automatic send(input longint l, input longint r, input bit mn, input bit an);
    longint el;
    longint er;
    el = scale(l, coef_of(m_idx), !an);
    er = scale(r, coef_of(m_idx), !an);
    model_step(!mn);
    in_valid = 1'b1;
    in_left = DW'(l);
    in_right = DW'(r);
    mute_n = mn;
    atten_n = an;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    mute_n = !mn;   // R8: idle-cycle values must be ignored
    atten_n = !an;
    in_left = DW'($urandom);
    in_right = DW'($urandom);
    chk(out_valid == 1'b0, "R10", "out_valid between pulses", longint'(out_valid), 0);
    chk(sx(out_left) == last_l && sx(out_right) == last_r, "R10", "held output",
        sx(out_left), last_l);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2", "out_valid two edges after strobe", longint'(out_valid), 1);
    chk(sx(out_left) == el, phase, "left result", sx(out_left), el);
    chk(sx(out_right) == er, phase, "right result", sx(out_right), er);
    last_l = el;
    last_r = er;
  endtask

  function automatic longint rnd20();
    return sx(DW'($urandom));
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 200000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    chk(out_left == '0 && out_right == '0, "R1", "outputs after reset", sx(out_left), 0);
    phase = "R1";
    send(123456, -98765, 1'b1, 1'b1);
    chk(last_l == 123456, "R3", "unity entry passes sample", last_l, 123456);

    // R2/R9: unity gain with extremes and random data
    phase = "R9";
    send(524287, -524288, 1'b1, 1'b1);
    send(-1, 1, 1'b1, 1'b1);
    send(0, 524287, 1'b1, 1'b1);
    phase = "R2";
    for (int i = 0; i < 20; i++) send(rnd20(), rnd20(), 1'b1, 1'b1);

    // R7: 12 dB cut, including half-way rounding cases
    phase = "R7";
    send(2, -2, 1'b1, 1'b0);
    send(6, -6, 1'b1, 1'b0);
    send(524287, -524288, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) send(rnd20(), rnd20(), 1'b1, 1'b0);

    // R4: full mute descent from the top entry, attenuation mixed in
    phase = "R4";
    for (int i = 0; i < 980; i++)
      send(((i % 2) == 0) ? 524287 : rnd20(), -524288, 1'b0, (i % 7) != 3);
    chk(m_idx == 0 && last_l == 0 && last_r == 0, "R4", "silent after descent", last_l, 0);
    phase = "R3";
    send(524287, -524288, 1'b0, 1'b1);

    // R5: release, climb back to unity
    phase = "R5";
    for (int i = 0; i < 980; i++) send(rnd20(), ((i % 3) == 0) ? -524288 : 524287, 1'b1, 1'b1);
    send(300001, -300001, 1'b1, 1'b1);
    chk(last_l == 300001, "R5", "unity after climb", last_l, 300001);

    // R6: reversals in the middle of a ramp
    phase = "R6";
    for (int i = 0; i < 100; i++) send(rnd20(), rnd20(), 1'b0, 1'b1);
    for (int i = 0; i < 45; i++) send(rnd20(), rnd20(), 1'b1, 1'b1);
    for (int i = 0; i < 70; i++) send(rnd20(), rnd20(), 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) send(rnd20(), rnd20(), i[0], 1'b1);
    for (int i = 0; i < 400; i++) send(rnd20(), rnd20(), 1'b1, 1'b1);

    // R8/R10: long idle with toggling controls leaves everything in place
    phase = "R8";
    for (int i = 0; i < 40; i++) begin
      mute_n = i[0];
      atten_n = i[1];
      @(negedge clk);
    end
    chk(out_valid == 1'b0 && sx(out_left) == last_l, "R10", "idle hold", sx(out_left), last_l);
    send(77777, -77777, 1'b1, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule